// File: doc/BRIEF.md
# GPIO port with interrupt detection

A 32-pin general-purpose I/O port controlled through a small word-addressed register bus. Software sets a per-pin output value and a per-pin direction, and reads back the synchronised level of every pad. Each pin can raise an interrupt on a low level, a high level, a rising edge, a falling edge, or any transition. Detected events are latched into a status register, and a mask register gates them onto two request lines: one for the lower sixteen pins and one for the upper sixteen.

Pad inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised level with its value one clock earlier. The bus has no handshake. A write completes on the clock edge where `bus_we_i` is high. Read data is combinational from the address. Address bits [1:0] are ignored, and word addresses that no register uses read as zero.

Top module: `gpio_irq_port`

## Requirements
- R1: The output value word (byte address 0x00) drives `pad_out_o`. The direction word (0x04) drives `pad_oe_o`: 1 means output, 0 means input.
- R2: The pad level word (0x08) returns `pad_in_i` delayed by two clocks, whatever the direction bits are.
- R3: The trigger codes are 2 bits per pin, held in word 0x0C (pins 0–15) and word 0x10 (pins 16–31). Pin n uses bits [2*(n mod 16)+1 : 2*(n mod 16)], and bit 4 of n selects the word.
- R4: Code 00 triggers on a low level and code 01 on a high level. The status bit is set again on every clock while the level holds, so a clear only sticks once the level is gone.
- R5: Code 10 sets status on a rising edge only, and code 11 on a falling edge only. An edge sets status once and does not set it again while the level stays.
- R6: A 1 in the any-edge word (0x1C) makes both transitions of that pin set status, and the pin's trigger code is then ignored.
- R7: Status (0x18) is cleared by writing 1 to a bit. Writing 0 leaves the bit unchanged. When a set and a clear land on the same clock, the set wins.
- R8: `irq_lo_o` is the OR of status AND mask (mask at 0x14) over pins 0–15. `irq_hi_o` is the same OR over pins 16–31.
- R9: While reset is asserted, every register reads zero and all outputs are zero.
- R10: The value words 0x00, 0x04, 0x0C, 0x10, 0x14 and 0x1C read back what was last written to them. Addresses 0x20–0x3C read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 6 | Byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| pad_in_i | input | 32 | Asynchronous pad levels |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| irq_lo_o | output | 1 | Request for pins 0–15 |
| irq_hi_o | output | 1 | Request for pins 16–31 |

## Verification
The assertions assume the pads are held steady around reset, so the synchroniser and the previous-level flop start from the same zero. They also assume that a write strobe is a clean single-cycle pulse with a stable address. The bench changes pads only on falling clock edges and only during reset or with reset released. It drives each write for exactly one cycle and then leaves the pads alone for several clocks before it samples status. For every pin and every trigger mode, the bench works out the expected status and request values from the idle and active pad levels it applied.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  localparam int W_DATA = 0;
  localparam int W_DIR  = 1;
  localparam int W_PAD  = 2;
  localparam int W_CFG0 = 3;
  localparam int W_CFG1 = 4;
  localparam int W_MASK = 5;
  localparam int W_STAT = 6;
  localparam int W_ANY  = 7;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
`timescale 1ns/1ps
module gpio_evt_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NPINS-1:0]   lvl_i,
  input  logic [2*NPINS-1:0] trig_i,
  input  logic [NPINS-1:0]   any_i,
  output logic [NPINS-1:0]   evt_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    trig_e code;
    assign code = trig_e'(trig_i[2*i +: 2]);
    always_comb begin
      if (any_i[i]) begin
        evt_o[i] = lvl_i[i] ^ prev_q[i];
      end else begin
        unique case (code)
          TRIG_LOW:  evt_o[i] = ~lvl_i[i];
          TRIG_HIGH: evt_o[i] = lvl_i[i];
          TRIG_RISE: evt_o[i] = lvl_i[i] & ~prev_q[i];
          TRIG_FALL: evt_o[i] = ~lvl_i[i] & prev_q[i];
          default:   evt_o[i] = 1'b0;
        endcase
      end
    end

    // edge codes never fire while the level is steady
    assert_edge_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!any_i[i] && trig_i[2*i+1] && lvl_i[i] == prev_q[i]) |-> !evt_o[i]);
  end
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [NPINS-1:0]   wdata_i,
  output logic [NPINS-1:0]   rdata_o,
  input  logic [NPINS-1:0]   lvl_i,
  input  logic [NPINS-1:0]   evt_i,
  output logic [NPINS-1:0]   data_o,
  output logic [NPINS-1:0]   dir_o,
  output logic [2*NPINS-1:0] cfg_o,
  output logic [NPINS-1:0]   any_o,
  output logic [NPINS-1:0]   mask_o,
  output logic [NPINS-1:0]   status_o
);
  localparam int WIDX_W    = ADDR_W - 2;
  localparam int NWORDS    = 1 << WIDX_W;
  localparam int CFG_WORDS = 2;

  logic [WIDX_W-1:0] widx;
  logic [NWORDS-1:0] sel;
  logic [NPINS-1:0]  data_q, dir_q, any_q, mask_q, status_q, clr;
  logic [2*NPINS-1:0] cfg_q;

  assign widx = addr_i[ADDR_W-1:2];

  for (genvar k = 0; k < NWORDS; k++) begin : g_sel
    assign sel[k] = we_i && (widx == WIDX_W'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      any_q  <= '0;
    end else begin
      if (sel[W_DATA]) data_q <= wdata_i;
      if (sel[W_DIR])  dir_q  <= wdata_i;
      if (sel[W_MASK]) mask_q <= wdata_i;
      if (sel[W_ANY])  any_q  <= wdata_i;
    end
  end

  for (genvar c = 0; c < CFG_WORDS; c++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cfg_q[c*NPINS +: NPINS] <= '0;
      else if (sel[W_CFG0 + c]) cfg_q[c*NPINS +: NPINS] <= wdata_i;
    end
  end

  assign clr = sel[W_STAT] ? wdata_i : '0;

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr) | evt_i;
  end

  always_comb begin
    case (widx)
      WIDX_W'(W_DATA): rdata_o = data_q;
      WIDX_W'(W_DIR):  rdata_o = dir_q;
      WIDX_W'(W_PAD):  rdata_o = lvl_i;
      WIDX_W'(W_CFG0): rdata_o = cfg_q[0 +: NPINS];
      WIDX_W'(W_CFG1): rdata_o = cfg_q[NPINS +: NPINS];
      WIDX_W'(W_MASK): rdata_o = mask_q;
      WIDX_W'(W_STAT): rdata_o = status_q;
      WIDX_W'(W_ANY):  rdata_o = any_q;
      default:         rdata_o = '0;
    endcase
  end

  assign data_o   = data_q;
  assign dir_o    = dir_q;
  assign cfg_o    = cfg_q;
  assign any_o    = any_q;
  assign mask_o   = mask_q;
  assign status_o = status_q;

  assert_dir_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx == WIDX_W'(W_DIR)) |=> dir_o == $past(wdata_i));

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    assert_status_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[i] && !(we_i && widx == WIDX_W'(W_STAT) && wdata_i[i])) |=> status_o[i]);
  end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int NGRP  = 2;
  localparam int GRP_W = NPINS / NGRP;

  logic [NPINS-1:0]   lvl, evt, any_q, mask_q, status_q, pend;
  logic [2*NPINS-1:0] cfg_q;
  logic [NGRP-1:0]    irq_grp;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (lvl)
  );

  gpio_evt_detect #(.NPINS(NPINS)) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .trig_i(cfg_q),
    .any_i (any_q),
    .evt_o (evt)
  );

  gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .we_i    (bus_we_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .lvl_i   (lvl),
    .evt_i   (evt),
    .data_o  (pad_out_o),
    .dir_o   (pad_oe_o),
    .cfg_o   (cfg_q),
    .any_o   (any_q),
    .mask_o  (mask_q),
    .status_o(status_q)
  );

  assign pend = status_q & mask_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_irq
    assign irq_grp[g] = |pend[g*GRP_W +: GRP_W];
  end

  assign irq_lo_o = irq_grp[0];
  assign irq_hi_o = irq_grp[NGRP-1];

  assert_mask_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !(irq_lo_o || irq_hi_o));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
    assert_level_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!any_q[i] && cfg_q[2*i +: 2] == TRIG_HIGH && lvl[i]) |=> status_q[i]);
    assert_level_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!any_q[i] && cfg_q[2*i +: 2] == TRIG_LOW && !lvl[i]) |=> status_q[i]);
    assert_any_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_q[i] && lvl[i] != $past(lvl[i])) |=> status_q[i]);
  end
endmodule

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_addr_i (addr),
    .bus_we_i   (we),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .pad_in_i   (pad_in),
    .pad_out_o  (pad_out),
    .pad_oe_o   (pad_oe),
    .irq_lo_o   (irq_lo),
    .irq_hi_o   (irq_hi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] cfg;
    logic [31:0] pats [4];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5A5_3C3C; pats[3] = 32'h5A5A_C3C3;

    // R9: reset state, sampled with reset held
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      addr = 6'(a * 4);
      #1 chk($sformatf("R9 reg %0d", a), rdata, '0);
    end
    chk("R9 outputs", {pad_out ^ pad_oe, 30'd0, irq_lo, irq_hi}, '0);
    chk("R9 oe", pad_oe, '0);
    @(negedge clk) rst_n = 1'b1;

    // R10: readback and unused space
    wr(6'h00, 32'hDEAD_BEEF); wr(6'h04, 32'h1234_5678); wr(6'h0C, 32'hAAAA_5555);
    wr(6'h10, 32'h0F0F_F0F0); wr(6'h14, 32'h8000_0001); wr(6'h1C, 32'hC001_0003);
    rd(6'h00, v); chk("R10 data", v, 32'hDEAD_BEEF);
    rd(6'h04, v); chk("R10 dir", v, 32'h1234_5678);
    rd(6'h0C, v); chk("R10 cfg0", v, 32'hAAAA_5555);
    rd(6'h10, v); chk("R10 cfg1", v, 32'h0F0F_F0F0);
    rd(6'h14, v); chk("R10 mask", v, 32'h8000_0001);
    rd(6'h1C, v); chk("R10 any", v, 32'hC001_0003);
    for (int a = 8; a < 16; a++) begin
      rd(6'(a * 4), v); chk("R10 unused", v, '0);
    end
    wr(6'h14, '0); wr(6'h1C, '0);

    // R1: pad drive
    wr(6'h04, 32'hFFFF_0000); wr(6'h00, 32'hA5A5_A5A5);
    @(negedge clk);
    chk("R1 out", pad_out, 32'hA5A5_A5A5);
    chk("R1 oe", pad_oe, 32'hFFFF_0000);
    wr(6'h04, 32'h0000_00FF);
    @(negedge clk);
    chk("R1 oe change", pad_oe, 32'h0000_00FF);

    // R2: pad readback, both directions, two-clock delay
    for (int d = 0; d < 2; d++) begin
      wr(6'h04, d ? 32'hFFFF_FFFF : 32'h0);
      for (int p = 0; p < 4; p++) begin
        @(negedge clk) pad_in = pats[p];
        settle();
        rd(6'h08, v); chk("R2 pad level", v, pats[p]);
      end
    end
    for (int k = 0; k < 32; k++) begin
      @(negedge clk) pad_in = 32'(1) << k;
      @(negedge clk); @(negedge clk);
      addr = 6'h08;
      #1 chk("R2 walking one delay", rdata, 32'(1) << k);
    end
    @(negedge clk) pad_in = '0;
    settle();

    // R3..R8: every pin, every trigger mode
    for (int n = 0; n < 32; n++) begin
      for (int m = 0; m < 5; m++) begin
        logic idle, act;
        logic [31:0] bit_n;
        string tg;
        bit_n = 32'(1) << n;
        idle = (m == 0 || m == 3);
        act  = ~idle;
        tg = (m < 2) ? "R4" : (m < 4) ? "R5" : "R6";
        cfg = {32{2'b10}};
        if (m < 4) cfg[2*n +: 2] = 2'(m);
        else       cfg[2*n +: 2] = 2'b00; // ignored under any-edge
        wr(6'h0C, cfg[31:0]);
        wr(6'h10, cfg[63:32]);
        wr(6'h1C, (m == 4) ? bit_n : '0);
        wr(6'h14, '0);
        @(negedge clk) begin pad_in = '0; pad_in[n] = idle; end
        settle();
        wr(6'h18, '1);
        rd(6'h18, v); chk($sformatf("R3 %s idle pin %0d mode %0d", tg, n, m), v, '0);

        @(negedge clk) pad_in[n] = act;
        settle();
        rd(6'h18, v); chk($sformatf("R3 %s active pin %0d mode %0d", tg, n, m), v, bit_n);
        chk("R8 masked off", {30'd0, irq_lo, irq_hi}, '0);
        wr(6'h14, bit_n);
        chk($sformatf("R8 request pin %0d", n), {30'd0, irq_lo, irq_hi},
            (n < 16) ? 32'd2 : 32'd1);

        wr(6'h18, '0);
        rd(6'h18, v); chk("R7 write zero", v, bit_n);
        wr(6'h18, bit_n);
        rd(6'h18, v);
        chk($sformatf("%s after clear pin %0d mode %0d", (m < 2) ? "R4" : "R7", n, m),
            v, (m < 2) ? bit_n : '0);

        @(negedge clk) pad_in[n] = idle;
        settle();
        rd(6'h18, v);
        chk($sformatf("%s return pin %0d mode %0d", tg, n, m), v,
            (m < 2 || m == 4) ? bit_n : '0);
        wr(6'h18, '1);
        rd(6'h18, v); chk($sformatf("%s cleared pin %0d mode %0d", tg, n, m), v, '0);
        chk("R8 drop", {30'd0, irq_lo, irq_hi}, '0);
      end
    end

    // R7: set wins over a same-cycle clear (rising edge on pin 5)
    cfg = {32{2'b10}};
    wr(6'h0C, cfg[31:0]); wr(6'h10, cfg[63:32]); wr(6'h1C, '0);
    @(negedge clk) pad_in = '0;
    settle();
    wr(6'h18, '1);
    @(negedge clk) pad_in[5] = 1'b1;   // first flop captures at next edge
    @(negedge clk);                    // second flop captures at next edge
    @(negedge clk) begin addr = 6'h18; wdata = '1; we = 1'b1; end
    @(negedge clk) we = 1'b0;
    #1 chk("R7 set wins", rdata, 32'h0000_0020);
    wr(6'h18, '1);
    rd(6'h18, v); chk("R7 clear after", v, '0);

    finished = 1;
    report();
  end
endmodule